// File: doc/BRIEF.md
# PHY Configuration Register Bank with Bit-Masked Writes

This block is a small memory-mapped register bank that configures the analog side of a storage-interface PHY. It holds seven 16-bit control words and one read-only status word. Software reaches them through a plain write port and a plain read port, each with a valid strobe, a byte address and a 32-bit data word. A write never replaces a whole word. The upper half of the write data is a per-bit enable for the lower half, so one field can change without disturbing its neighbours and without a read-modify-write.

The bank decodes the clock-frequency, output-tap and power/DLL/drive fields onto dedicated output pins that go straight to the PHY. It samples two status levels from the PHY every cycle, calibration done and DLL ready, and returns them in the status word. Reads are registered. The read data for a request appears one cycle after the strobe and holds until the next request.

Top module: `phycfg_regbank`

## Requirements
- R1: On a write, bit x of the addressed control word (x in 0..15) takes data bit x only when data bit x+16 is 1. Every other bit of that word and of all other words keeps its value.
- R2: Control words 0 to 6 are addressed at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. A write to any other offset, including the status offset 0x20 and offsets that are not word-aligned, changes no stored bit and no output.
- R3: A read of a control word returns its 16 stored bits in rd_data[15:0], with rd_data[31:16] zero.
- R4: A read of any offset that is neither a control word nor 0x20 returns zero.
- R5: A read at offset 0x20 returns calibration done in bit 6 and DLL ready in bit 5, as sampled one cycle before the read strobe. All other bits are zero.
- R6: Word 0 drives freq_sel from bits 13:12 (0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz), otap_en from bit 11 and otap_sel from bits 10:7.
- R7: Word 6 drives pwr_on from bit 0 (1 = analog powered), dll_en from bit 1 and drv_sel from bits 6:4 (0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm, 4 = 40 ohm).
- R8: A synchronous active-high reset clears every control bit and rd_data. The PHY is then left powered down with its DLL disabled.
- R9: rd_data updates on the clock edge that follows a cycle with rd_valid high. It holds its value in every other cycle, including cycles with writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Bits 31:16 are per-bit enables, bits 15:0 are the value |
| rd_valid | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration done level from the PHY |
| dll_ready_i | input | 1 | DLL ready level from the PHY |
| freq_sel | output | 2 | DLL frequency select |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay select |
| pwr_on | output | 1 | Analog power-up control (1 = on) |
| dll_en | output | 1 | DLL enable |
| drv_sel | output | 3 | Drive impedance select |

## Verification
On every cycle the assertions check the following. A masked-off bit of the power word leaves pwr_on unchanged, and an enabled bit lands on it. Writes to the status offset or to unmapped offsets move no output. Control-word reads have a zero upper half and unmapped reads return zero. The status bits follow the PHY inputs with the stated delay, and rd_data holds when no read is issued. The properties cannot show the full contents of all seven words after arbitrary masked writes, the exact value of each field encoding, or the clean state after a reset in mid-operation. The bench's sweeps cover these with a model of the stored words.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

   // Field positions used by the PHY (behavioural, decoded by the field map)
   localparam int FREQ_LSB     = 12;
   localparam int OTAP_EN_BIT  = 11;
   localparam int OTAP_SEL_LSB = 7;
   localparam int PDB_BIT      = 0;
   localparam int DLL_EN_BIT   = 1;
   localparam int DRV_LSB      = 4;
   localparam int CAL_BIT      = 6;
   localparam int RDY_BIT      = 5;

   // Which control words carry the decoded fields
   localparam int CLK_WORD     = 0;
   localparam int PWR_WORD     = 6;

   typedef enum logic [1:0] {
      FREQ_200 = 2'd0,
      FREQ_50  = 2'd1,
      FREQ_100 = 2'd2,
      FREQ_150 = 2'd3
   } freq_e;

   typedef enum logic [2:0] {
      DRV_50R  = 3'd0,
      DRV_33R  = 3'd1,
      DRV_66R  = 3'd2,
      DRV_100R = 3'd3,
      DRV_40R  = 3'd4
   } drv_e;

   typedef struct packed {
      freq_e      freq;
      logic       otap_en;
      logic [3:0] otap_sel;
      logic       pwr_on;
      logic       dll_en;
      drv_e       drv;
   } phy_fields_t;

endpackage

// File: rtl/phycfg_mask_word.sv
module phycfg_mask_word #(
   parameter int HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                we,
   input  logic [2*HALF_W-1:0] wdata,
   output logic [HALF_W-1:0]   q
);
   logic [HALF_W-1:0] en_bits;
   logic [HALF_W-1:0] val_bits;

   assign en_bits  = wdata[2*HALF_W-1:HALF_W];
   assign val_bits = wdata[HALF_W-1:0];

   // one flop per bit, each gated by its own enable
   for (genvar b = 0; b < HALF_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)
            q[b] <= 1'b0;
         else if (we && en_bits[b])
            q[b] <= val_bits[b];
      end
   end
endmodule

// File: rtl/phycfg_addr_dec.sv
module phycfg_addr_dec #(
   parameter int ADDR_W     = 8,
   parameter int NUM_CTRL   = 7,
   parameter int STATUS_OFS = 32
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_CTRL-1:0] ctrl_hit,
   output logic                stat_hit
);
   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_hit
      localparam logic [ADDR_W-1:0] OFS = ADDR_W'(4 * i);
      assign ctrl_hit[i] = (addr == OFS);
   end

   assign stat_hit = (addr == ADDR_W'(STATUS_OFS));
endmodule

// File: rtl/phycfg_field_map.sv
module phycfg_field_map
   import phycfg_pkg::*;
#(
   parameter int NUM_CTRL = 7,
   parameter int HALF_W   = 16
) (
   input  logic [NUM_CTRL-1:0][HALF_W-1:0] words,
   output phy_fields_t                     fields
);
   logic [HALF_W-1:0] clk_w;
   logic [HALF_W-1:0] pwr_w;

   assign clk_w = words[CLK_WORD];
   assign pwr_w = words[PWR_WORD];

   always_comb begin
      fields.freq     = freq_e'(clk_w[FREQ_LSB +: 2]);
      fields.otap_en  = clk_w[OTAP_EN_BIT];
      fields.otap_sel = clk_w[OTAP_SEL_LSB +: 4];
      fields.pwr_on   = pwr_w[PDB_BIT];
      fields.dll_en   = pwr_w[DLL_EN_BIT];
      fields.drv      = drv_e'(pwr_w[DRV_LSB +: 3]);
   end
endmodule

// File: rtl/phycfg_rd_path.sv
module phycfg_rd_path
   import phycfg_pkg::*;
#(
   parameter int NUM_CTRL = 7,
   parameter int HALF_W   = 16,
   parameter bit RD_PIPE  = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            rd_valid,
   input  logic [NUM_CTRL-1:0]             ctrl_hit,
   input  logic                            stat_hit,
   input  logic [NUM_CTRL-1:0][HALF_W-1:0] words,
   input  logic [1:0]                      stat_q,
   output logic [2*HALF_W-1:0]             rd_data
);
   localparam int DW = 2 * HALF_W;

   logic [DW-1:0] sel_word;

   always_comb begin
      sel_word = '0;
      for (int i = 0; i < NUM_CTRL; i++)
         if (ctrl_hit[i])
            sel_word = {{HALF_W{1'b0}}, words[i]};
      if (stat_hit) begin
         sel_word[CAL_BIT] = stat_q[1];
         sel_word[RDY_BIT] = stat_q[0];
      end
   end

   if (RD_PIPE) begin : g_pipe
      always_ff @(posedge clk) begin
         if (rst)
            rd_data <= '0;
         else if (rd_valid)
            rd_data <= sel_word;
      end
   end else begin : g_comb
      assign rd_data = rd_valid ? sel_word : '0;
   end
endmodule

// File: rtl/phycfg_regbank.sv
module phycfg_regbank
   import phycfg_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int NUM_CTRL   = 7,
   parameter int STATUS_OFS = 32,
   parameter bit RD_PIPE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cal_done_i,
   input  logic              dll_ready_i,
   output logic [1:0]        freq_sel,
   output logic              otap_en,
   output logic [3:0]        otap_sel,
   output logic              pwr_on,
   output logic              dll_en,
   output logic [2:0]        drv_sel
);
   localparam int HALF_W = DATA_W / 2;

   // elaboration-time parameter checks
   if (DATA_W % 2 != 0 || HALF_W < 16) begin : g_bad_width
      $error("DATA_W must be even and at least 32");
   end
   if (NUM_CTRL <= PWR_WORD) begin : g_bad_count
      $error("NUM_CTRL must cover the power word");
   end
   if (STATUS_OFS < 4 * NUM_CTRL || STATUS_OFS % 4 != 0) begin : g_bad_stat
      $error("STATUS_OFS must be word aligned and above the control words");
   end
   if (STATUS_OFS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for STATUS_OFS");
   end

   logic [NUM_CTRL-1:0]             wr_hit;
   logic                            wr_stat_unused;
   logic [NUM_CTRL-1:0]             rd_hit;
   logic                            rd_stat;
   logic [NUM_CTRL-1:0][HALF_W-1:0] words;
   logic [1:0]                      stat_q;
   phy_fields_t                     fields;

   phycfg_addr_dec #(
      .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .STATUS_OFS(STATUS_OFS)
   ) u_wdec (
      .addr(wr_addr), .ctrl_hit(wr_hit), .stat_hit(wr_stat_unused)
   );

   phycfg_addr_dec #(
      .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .STATUS_OFS(STATUS_OFS)
   ) u_rdec (
      .addr(rd_addr), .ctrl_hit(rd_hit), .stat_hit(rd_stat)
   );

   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_word
      phycfg_mask_word #(.HALF_W(HALF_W)) u_word (
         .clk  (clk),
         .rst  (rst),
         .we   (wr_valid && wr_hit[i]),
         .wdata(wr_data),
         .q    (words[i])
      );
   end

   // PHY status levels, sampled every cycle
   always_ff @(posedge clk) stat_q <= {cal_done_i, dll_ready_i};

   phycfg_field_map #(.NUM_CTRL(NUM_CTRL), .HALF_W(HALF_W)) u_map (
      .words (words),
      .fields(fields)
   );

   phycfg_rd_path #(
      .NUM_CTRL(NUM_CTRL), .HALF_W(HALF_W), .RD_PIPE(RD_PIPE)
   ) u_rd (
      .clk     (clk),
      .rst     (rst),
      .rd_valid(rd_valid),
      .ctrl_hit(rd_hit),
      .stat_hit(rd_stat),
      .words   (words),
      .stat_q  (stat_q),
      .rd_data (rd_data)
   );

   assign freq_sel = fields.freq;
   assign otap_en  = fields.otap_en;
   assign otap_sel = fields.otap_sel;
   assign pwr_on   = fields.pwr_on;
   assign dll_en   = fields.dll_en;
   assign drv_sel  = fields.drv;
endmodule

// File: rtl/phycfg_regbank_chk.sv
module phycfg_regbank_chk #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int NUM_CTRL   = 7,
   parameter int STATUS_OFS = 32,
   parameter bit RD_PIPE    = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              cal_done_i,
   input logic              dll_ready_i,
   input logic [1:0]        freq_sel,
   input logic              otap_en,
   input logic [3:0]        otap_sel,
   input logic              pwr_on,
   input logic              dll_en,
   input logic [2:0]        drv_sel
);
   localparam int HW = DATA_W / 2;
   localparam logic [ADDR_W-1:0] PWR_OFS  = ADDR_W'(24);
   localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(STATUS_OFS);

   logic wr_ctrl;
   logic rd_ctrl;
   logic [13:0] outs;

   assign wr_ctrl = (wr_addr[1:0] == 2'b00) && ((wr_addr >> 2) < NUM_CTRL);
   assign rd_ctrl = (rd_addr[1:0] == 2'b00) && ((rd_addr >> 2) < NUM_CTRL);
   assign outs    = {freq_sel, otap_en, otap_sel, pwr_on, dll_en, drv_sel};

   // R1
   pwr_masked_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_addr == PWR_OFS && !wr_data[HW]) |=> $stable(pwr_on));

   // R1
   pwr_enabled_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_addr == PWR_OFS && wr_data[HW]) |=> (pwr_on == $past(wr_data[0])));

   // R2
   stray_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_ctrl) |=> $stable(outs));

   // R3
   ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && rd_ctrl) |=> (rd_data[DATA_W-1:HW] == '0));

   // R4
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && !rd_ctrl && rd_addr != STAT_OFS) |=> (rd_data == '0));

   // R5
   status_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && rd_addr == STAT_OFS) |=>
         (rd_data == ((DATA_W'($past(cal_done_i, 2)) << 6) | (DATA_W'($past(dll_ready_i, 2)) << 5))));

   // R8
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (!pwr_on && !dll_en && freq_sel == 2'd0 && drv_sel == 3'd0 && rd_data == '0));

   if (RD_PIPE) begin : g_hold
      // R9
      rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !rd_valid |=> $stable(rd_data));
   end
endmodule

bind phycfg_regbank phycfg_regbank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL),
   .STATUS_OFS(STATUS_OFS), .RD_PIPE(RD_PIPE)
) u_chk (
   .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
   .rd_data(rd_data), .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i),
   .freq_sel(freq_sel), .otap_en(otap_en), .otap_sel(otap_sel),
   .pwr_on(pwr_on), .dll_en(dll_en), .drv_sel(drv_sel)
);

// File: tb/tb_phycfg_regbank.sv
module tb_phycfg_regbank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_valid;
   logic [7:0]  wr_addr;
   logic [31:0] wr_data;
   logic        rd_valid;
   logic [7:0]  rd_addr;
   logic [31:0] rd_data;
   logic        cal_done_i;
   logic        dll_ready_i;
   logic [1:0]  freq_sel;
   logic        otap_en;
   logic [3:0]  otap_sel;
   logic        pwr_on;
   logic        dll_en;
   logic [2:0]  drv_sel;

   int checks = 0;
   int errors = 0;
   logic [15:0] mdl [7];

   always #(CLK_PERIOD/2) clk = ~clk;

   phycfg_regbank dut (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_data(rd_data), .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i),
      .freq_sel(freq_sel), .otap_en(otap_en), .otap_sel(otap_sel),
      .pwr_on(pwr_on), .dll_en(dll_en), .drv_sel(drv_sel)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      if (a[1:0] == 2'b00 && (a >> 2) < 7)
         mdl[a >> 2] = (mdl[a >> 2] & ~d[31:16]) | (d[15:0] & d[31:16]);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_valid = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_valid = 1'b0;
      d = rd_data;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] held;
      rst = 1'b1; wr_valid = 0; wr_addr = 0; wr_data = 0;
      rd_valid = 0; rd_addr = 0; cal_done_i = 0; dll_ready_i = 0;
      for (int i = 0; i < 7; i++) mdl[i] = 16'h0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R8: reset state
      check("R8 pwr/dll", {30'b0, pwr_on, dll_en}, 32'd0);
      check("R8 fields", {21'b0, freq_sel, otap_en, otap_sel, drv_sel}, 32'd0);
      check("R8 rd_data", rd_data, 32'd0);

      // R1 R2 R3: masked write sweep over every control word
      for (int r = 0; r < 7; r++) begin
         for (int k = 0; k < 8; k++) begin
            logic [15:0] m;
            logic [15:0] d;
            m = (16'hFFFF >> (2 * k)) ^ 16'(r * 16'h1111);
            d = 16'(16'hA5C3 * (k + 1) + r * 16'h0F0F);
            wr(8'(4 * r), {m, d});
            rd(8'(4 * r), v);
            check("R1 R3 masked readback", v, {16'h0, mdl[r]});
         end
      end

      // R2: writes to status, unaligned and unmapped offsets change nothing
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h1C, 32'hFFFF_FFFF);
      wr(8'h02, 32'hFFFF_FFFF);
      wr(8'h19, 32'hFFFF_0000);
      wr(8'h3C, 32'hFFFF_FFFF);
      wr(8'hFC, 32'hFFFF_0000);
      for (int r = 0; r < 7; r++) begin
         rd(8'(4 * r), v);
         check("R2 stray write ignored", v, {16'h0, mdl[r]});
      end

      // R3 R4 R5: read sweep of offsets 0..63 with status 0
      cal_done_i = 1'b0; dll_ready_i = 1'b0;
      @(negedge clk);
      for (int a = 0; a < 64; a++) begin
         logic [31:0] e;
         if (a % 4 == 0 && a / 4 < 7) e = {16'h0, mdl[a / 4]};
         else e = 32'h0;
         rd(8'(a), v);
         check("R3 R4 R5 address sweep", v, e);
      end

      // R5: status combinations (bit 6 cal done, bit 5 dll ready)
      for (int s = 0; s < 4; s++) begin
         cal_done_i = s[1]; dll_ready_i = s[0];
         @(negedge clk);
         rd(8'h20, v);
         check("R5 status", v, (32'(s[1]) << 6) | (32'(s[0]) << 5));
      end

      // R6: word 0 field decoding
      wr(8'h00, 32'hFFFF_0000);
      for (int f = 0; f < 4; f++) begin
         wr(8'h00, {16'h3000, 16'(f << 12)});
         check("R6 freq_sel", {30'b0, freq_sel}, 32'(f));
      end
      for (int t = 0; t < 16; t++) begin
         wr(8'h00, {16'h0F80, 16'(t << 7)});
         check("R6 otap_sel", {28'b0, otap_sel}, 32'(t));
      end
      wr(8'h00, 32'h0800_0800);
      check("R6 otap_en set", {31'b0, otap_en}, 32'd1);
      wr(8'h00, 32'h0800_0000);
      check("R6 otap_en clear", {31'b0, otap_en}, 32'd0);

      // R7: word 6 field decoding
      wr(8'h18, 32'hFFFF_0000);
      for (int g = 0; g < 8; g++) begin
         wr(8'h18, {16'h0070, 16'(g << 4)});
         check("R7 drv_sel", {29'b0, drv_sel}, 32'(g));
      end
      wr(8'h18, 32'h0001_0001);
      check("R7 pwr_on only", {30'b0, pwr_on, dll_en}, 32'h2);
      wr(8'h18, 32'h0002_0002);
      check("R7 dll_en", {30'b0, pwr_on, dll_en}, 32'h3);
      wr(8'h18, 32'h0000_0000);
      check("R1 zero mask keeps", {30'b0, pwr_on, dll_en}, 32'h3);

      // R9: rd_data holds through idle and write cycles
      rd(8'h18, held);
      wr(8'h18, 32'hFFFF_1234);
      wr(8'h04, 32'hFFFF_BEEF);
      @(negedge clk);
      check("R9 rd_data holds", rd_data, held);

      // R8: reset in mid-operation
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 7; i++) mdl[i] = 16'h0;
      check("R8 mid reset pwr/dll", {30'b0, pwr_on, dll_en}, 32'd0);
      check("R8 mid reset rd_data", rd_data, 32'd0);
      for (int r = 0; r < 7; r++) begin
         rd(8'(4 * r), v);
         check("R8 words cleared", v, 32'd0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule